// File: doc/BRIEF.md
# SD Command Line Engine

This block drives the command line of an SD card interface for one command at a time. Software loads a 32-bit argument and then writes a command word carrying a 6-bit index, a response-expected bit, a long-response bit and a start bit. On the start bit the block builds a 48-bit frame, appends a CRC7, and shifts the frame out most significant bit first. It moves forward one bit on each cycle where the card clock enable `card_tick` is high.

When a response is expected, the block releases the line and waits for a start bit from the card. It then captures either a 48-bit short response or a 136-bit long response into four 32-bit response words. Completion is reported through sticky status flags, one for each outcome: sent without response, response received, response CRC mismatch and timeout. A write-one-to-clear port removes the flags. A live busy bit follows the command from launch to completion.

Top module: `sd_cmd_path`

## Requirements
- R1: Writing the command word with bit 10 set while idle launches a command. The word carries the index in bits [5:0], response expected at bit 6 and long response at bit 7. Status bit 11 (busy) is high from the cycle after the launch until the cycle in which completion is flagged.
- R2: The frame is 48 bits sent MSB first, one bit per `card_tick`: start 0, transmission 1, index, argument, CRC7 over those first 40 bits (polynomial x^7+x^3+1, zero seed), stop 1. `cmd_oe` is high only while the frame is driven, and `cmd_out` idles at 1.
- R3: Without response expected, status bit 7 (sent) is set in the cycle after the stop bit's tick.
- R4: With response expected, a start bit (0 on `cmd_in`) seen on any of the 64 ticks after the stop bit begins capture. If none is seen, status bit 2 (timeout) is set on the 64th tick and busy drops.
- R5: A short response is 48 bits. Its 32 payload bits (after start, transmission and 6 index bits) go into `resp0`, and `resp1`..`resp3` keep their values. Its CRC7 over the 40 bits before the CRC field is compared: a match sets status bit 6 (response end), a mismatch sets status bit 0 (CRC fail). `resp0` is updated in both cases.
- R6: A long response is 136 bits. The 128 bits after its 8-bit header fill `resp0` (most significant) through `resp3`. No CRC is checked, and status bit 6 is set.
- R7: A short response to a command with index 41 is never checked for CRC and always sets status bit 6.
- R8: Flags (bits 0, 2, 6, 7) stay set until a clear write with a 1 in the matching bit position of `clr_wdata`. Other flags are untouched, and 0x7FF clears all. All other status bits read 0.
- R9: Command word bits 8 and 9 have no effect on the frame or the outcome.
- R10: While busy, a command write with bit 10 set is ignored, and an argument write does not alter the frame in flight. A command write with bit 10 clear aborts: the line is released and busy drops in the next cycle, with no flag set.
- R11: With `card_tick` low, the frame, the wait timer and capture all hold.
- R12: After reset, status reads 0, `cmd_oe` is 0, `cmd_out` is 1 and all response words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_tick | input | 1 | Card clock enable, one bit time per high cycle |
| arg_we | input | 1 | Argument write strobe |
| arg_wdata | input | 32 | Argument write data |
| cmdw_we | input | 1 | Command word write strobe |
| cmdw_wdata | input | 11 | Command word write data |
| clr_we | input | 1 | Flag clear write strobe |
| clr_wdata | input | 11 | Flag clear mask, one clears the matching flag |
| cmd_in | input | 1 | Command line as sampled from the card |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| status | output | 12 | Flags and busy bit |
| resp0 | output | 32 | Response word 0 |
| resp1 | output | 32 | Response word 1 |
| resp2 | output | 32 | Response word 2 |
| resp3 | output | 32 | Response word 3 |

## Verification
Frames are checked bit by bit for commands with and without a response. One frame is stalled by dropping the card tick, and another has a second launch and an argument change injected mid-flight. These cases separate true progress on ticks from free-running logic, and a snapshotted frame from a live one. Card replies cover:
- a short reply with a good CRC;
- a short reply with a corrupted CRC;
- the same bad CRC on index 41;
- a long reply;
- silence, to force a timeout;
- a start bit on exactly the last allowed tick.

Together these tell apart the completion flags, the CRC exemptions, the word-fill order and the off-by-one limit of the timeout window. Selective and full clears, and an abort during a pending command, show that the flags are sticky and independent.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2,
    ST_RECV = 2'd3
  } cmd_state_e;

  localparam int CRC_W = 7;

  // command word fields
  localparam int CW_RESP = 6;
  localparam int CW_LONG = 7;
  localparam int CW_EN   = 10;

  // status positions (decoded by software, kept fixed)
  localparam int SB_CRCFAIL = 0;
  localparam int SB_TIMEOUT = 2;
  localparam int SB_RESPEND = 6;
  localparam int SB_SENT    = 7;
  localparam int SB_BUSY    = 11;

  function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  function automatic logic [CRC_W-1:0] crc7_bits(input logic [63:0] d, input int n);
    logic [CRC_W-1:0] c;
    c = '0;
    for (int k = 63; k >= 0; k--) begin
      if (k < n) c = crc7_step(c, d[k]);
    end
    return c;
  endfunction

endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7 import sdcmd_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             en,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);

  logic [CRC_W-1:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clear)   crc_d = '0;
    else if (en) crc_d = crc7_step(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;

endmodule

// File: rtl/sdcmd_tx.sv
module sdcmd_tx #(
  parameter int FRAME_W = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic               shift,
  output logic               bit_out,
  output logic               last
);

  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (load) begin
      sh_d  = frame;
      cnt_d = TOP;
    end else if (shift) begin
      sh_d = {sh_q[FRAME_W-2:0], 1'b1};
      if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      cnt_q <= '0;
    end else if (load || shift) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign bit_out = sh_q[FRAME_W-1];
  assign last    = (cnt_q == '0);

endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx import sdcmd_pkg::*; #(
  parameter int SHORT_W  = 48,
  parameter int LONG_W   = 136,
  parameter int CRC_SPAN = 39
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              sample,
  input  logic              long_mode,
  input  logic              din,
  output logic [LONG_W-2:0] body,
  output logic              done,
  output logic              crc_ok
);

  localparam int BODY_W = LONG_W - 1;
  localparam int CNT_W  = $clog2(LONG_W);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_W - 2);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_W - 2);
  localparam logic [CNT_W-1:0] SPAN       = CNT_W'(CRC_SPAN);

  logic [BODY_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              done_q, done_d;
  logic [CNT_W-1:0]  last_idx;
  logic [CRC_W-1:0]  crc_v;

  assign last_idx = long_mode ? LONG_LAST : SHORT_LAST;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (arm) begin
      sh_d  = '0;
      cnt_d = '0;
    end else if (sample) begin
      sh_d   = {sh_q[BODY_W-2:0], din};
      cnt_d  = cnt_q + CNT_W'(1);
      done_d = (cnt_q == last_idx);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (arm || sample) begin
        sh_q  <= sh_d;
        cnt_q <= cnt_d;
      end
    end
  end

  sdcmd_crc7 u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (arm),
    .en    (sample && !arm && (cnt_q < SPAN)),
    .din   (din),
    .crc   (crc_v)
  );

  assign body   = sh_q;
  assign done   = done_q;
  assign crc_ok = (crc_v == sh_q[CRC_W:1]);

endmodule

// File: rtl/sd_cmd_path.sv
module sd_cmd_path import sdcmd_pkg::*; #(
  parameter int TIMEOUT_TICKS = 64,
  parameter int OCR_INDEX     = 41,
  parameter int ARG_W         = 32,
  parameter int IDX_W         = 6,
  parameter int RESP_WORDS    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             card_tick,
  input  logic             arg_we,
  input  logic [ARG_W-1:0] arg_wdata,
  input  logic             cmdw_we,
  input  logic [10:0]      cmdw_wdata,
  input  logic             clr_we,
  input  logic [10:0]      clr_wdata,
  input  logic             cmd_in,
  output logic             cmd_out,
  output logic             cmd_oe,
  output logic [11:0]      status,
  output logic [31:0]      resp0,
  output logic [31:0]      resp1,
  output logic [31:0]      resp2,
  output logic [31:0]      resp3
);

  localparam int HEAD_W   = 2 + IDX_W + ARG_W;
  localparam int FRAME_W  = HEAD_W + CRC_W + 1;
  localparam int LONG_W   = 8 + RESP_WORDS * 32;
  localparam int BODY_W   = LONG_W - 1;
  localparam int TMR_W    = $clog2(TIMEOUT_TICKS);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_TICKS - 1);
  localparam logic [IDX_W-1:0] OCR_IDX  = IDX_W'(OCR_INDEX);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_i = rs_q[1];

  cmd_state_e       state_q, state_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [ARG_W-1:0] arg_q;
  logic [IDX_W-1:0] idx_q;
  logic             rexp_q, long_q;
  logic             f_crc_q, f_to_q, f_re_q, f_sent_q;
  logic             set_crc, set_to, set_re, set_sent;
  logic             launch, abort;
  logic             tx_load, tx_bit, tx_last;
  logic             rx_arm, rx_done, rx_ok;
  logic [BODY_W-1:0] rx_body;
  logic             resp_load;
  logic [FRAME_W-1:0] frame;
  logic [IDX_W-1:0]   new_idx;
  logic [31:0]        resp_q [RESP_WORDS];

  assign new_idx = cmdw_wdata[IDX_W-1:0];
  assign launch  = cmdw_we && cmdw_wdata[CW_EN] && (state_q == ST_IDLE);
  assign abort   = cmdw_we && !cmdw_wdata[CW_EN] && (state_q != ST_IDLE);
  assign frame   = {2'b01, new_idx, arg_q,
                    crc7_bits(64'({2'b01, new_idx, arg_q}), HEAD_W), 1'b1};

  // next-state logic
  always_comb begin
    state_d   = state_q;
    tmr_d     = tmr_q;
    tx_load   = 1'b0;
    rx_arm    = 1'b0;
    resp_load = 1'b0;
    set_crc   = 1'b0;
    set_to    = 1'b0;
    set_re    = 1'b0;
    set_sent  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (launch) begin
          state_d = ST_SEND;
          tx_load = 1'b1;
        end
      end
      ST_SEND: begin
        if (abort) state_d = ST_IDLE;
        else if (card_tick && tx_last) begin
          if (rexp_q) begin
            state_d = ST_WAIT;
            tmr_d   = '0;
          end else begin
            state_d  = ST_IDLE;
            set_sent = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (abort) state_d = ST_IDLE;
        else if (card_tick) begin
          if (!cmd_in) begin
            state_d = ST_RECV;
            rx_arm  = 1'b1;
          end else if (tmr_q == TMR_LAST) begin
            state_d = ST_IDLE;
            set_to  = 1'b1;
          end else begin
            tmr_d = tmr_q + TMR_W'(1);
          end
        end
      end
      ST_RECV: begin
        if (abort) state_d = ST_IDLE;
        else if (rx_done) begin
          state_d   = ST_IDLE;
          resp_load = 1'b1;
          if (long_q || (idx_q == OCR_IDX) || rx_ok) set_re = 1'b1;
          else                                       set_crc = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) arg_q <= '0;
    else if (arg_we) arg_q <= arg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      idx_q  <= '0;
      rexp_q <= 1'b0;
      long_q <= 1'b0;
    end else if (launch) begin
      idx_q  <= new_idx;
      rexp_q <= cmdw_wdata[CW_RESP];
      long_q <= cmdw_wdata[CW_RESP] && cmdw_wdata[CW_LONG];
    end
  end

  // sticky flags: a set in the same cycle wins over a clear
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      f_crc_q  <= 1'b0;
      f_to_q   <= 1'b0;
      f_re_q   <= 1'b0;
      f_sent_q <= 1'b0;
    end else begin
      f_crc_q  <= set_crc  | (f_crc_q  & ~(clr_we & clr_wdata[SB_CRCFAIL]));
      f_to_q   <= set_to   | (f_to_q   & ~(clr_we & clr_wdata[SB_TIMEOUT]));
      f_re_q   <= set_re   | (f_re_q   & ~(clr_we & clr_wdata[SB_RESPEND]));
      f_sent_q <= set_sent | (f_sent_q & ~(clr_we & clr_wdata[SB_SENT]));
    end
  end

  sdcmd_tx #(.FRAME_W(FRAME_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .load    (tx_load),
    .frame   (frame),
    .shift   (card_tick && (state_q == ST_SEND) && !abort),
    .bit_out (tx_bit),
    .last    (tx_last)
  );

  sdcmd_rx #(.SHORT_W(FRAME_W), .LONG_W(LONG_W), .CRC_SPAN(HEAD_W - 1)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .arm       (rx_arm),
    .sample    (card_tick && (state_q == ST_RECV) && !rx_done),
    .long_mode (long_q),
    .din       (cmd_in),
    .body      (rx_body),
    .done      (rx_done),
    .crc_ok    (rx_ok)
  );

  // response words: word 0 takes the short payload, all take the long body
  for (genvar g = 0; g < RESP_WORDS; g++) begin : g_resp
    localparam int HI = (RESP_WORDS - g) * 32 - 1;
    always_ff @(posedge clk or negedge rst_n_i) begin
      if (!rst_n_i) resp_q[g] <= '0;
      else if (resp_load && long_q) resp_q[g] <= rx_body[HI -: 32];
      else if (resp_load && (g == 0)) resp_q[g] <= rx_body[CRC_W+32:CRC_W+1];
    end
  end

  always_comb begin
    status             = '0;
    status[SB_CRCFAIL] = f_crc_q;
    status[SB_TIMEOUT] = f_to_q;
    status[SB_RESPEND] = f_re_q;
    status[SB_SENT]    = f_sent_q;
    status[SB_BUSY]    = (state_q != ST_IDLE);
  end

  assign cmd_oe  = (state_q == ST_SEND);
  assign cmd_out = (state_q == ST_SEND) ? tx_bit : 1'b1;
  assign resp0   = resp_q[0];
  assign resp1   = resp_q[1];
  assign resp2   = resp_q[2];
  assign resp3   = resp_q[3];

endmodule

// File: rtl/sd_cmd_path_chk.sv
module sd_cmd_path_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_oe,
  input logic        cmd_out,
  input logic [11:0] status,
  input logic        clr_we,
  input logic [10:0] clr_wdata
);

  // R2
  line_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_oe |-> cmd_out);

  // R2
  frame_starts_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |-> !cmd_out);

  // R1
  drive_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> status[11]);

  // R3
  sent_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[7]) |-> $past(status[11]));

  // R4
  timeout_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> ($past(status[11]) && !cmd_oe));

  // R5
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(status[0]) && $rose(status[6])));

  // R8
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_wdata[6] && !status[11]) |=> !status[6]);

endmodule

bind sd_cmd_path sd_cmd_path_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_oe    (cmd_oe),
  .cmd_out   (cmd_out),
  .status    (status),
  .clr_we    (clr_we),
  .clr_wdata (clr_wdata)
);

// File: tb/test_sd_cmd_path.sv
module test_sd_cmd_path;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        card_tick = 1'b1;
  logic        arg_we = 1'b0;
  logic [31:0] arg_wdata = '0;
  logic        cmdw_we = 1'b0;
  logic [10:0] cmdw_wdata = '0;
  logic        clr_we = 1'b0;
  logic [10:0] clr_wdata = '0;
  logic        cmd_in = 1'b1;
  logic        cmd_out, cmd_oe;
  logic [11:0] status;
  logic [31:0] resp0, resp1, resp2, resp3;

  int n_chk = 0;
  int n_fail = 0;
  logic [11:0] exp_st = '0;
  logic [31:0] exp_r [4] = '{default: 32'h0};

  always #4 clk = ~clk;

  sd_cmd_path i_sd_cmd_path (
    .clk(clk), .rst_n(rst_n), .card_tick(card_tick),
    .arg_we(arg_we), .arg_wdata(arg_wdata),
    .cmdw_we(cmdw_we), .cmdw_wdata(cmdw_wdata),
    .clr_we(clr_we), .clr_wdata(clr_wdata),
    .cmd_in(cmd_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
    .status(status), .resp0(resp0), .resp1(resp1), .resp2(resp2), .resp3(resp3)
  );

  task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_crc(input logic [39:0] d);
    logic [6:0] c = '0;
    for (int k = 39; k >= 0; k--) begin
      if (d[k] ^ c[6]) c = {c[5:0], 1'b0} ^ 7'h09;
      else             c = {c[5:0], 1'b0};
    end
    return c;
  endfunction

  task automatic check_resp(input string rq);
    chk(resp0 === exp_r[0], rq, resp0, exp_r[0]);
    chk({resp1, resp2, resp3} === {exp_r[1], exp_r[2], exp_r[3]}, rq,
        {resp1, resp2, resp3}, {exp_r[1], exp_r[2], exp_r[3]});
  endtask

  task automatic clear(input logic [10:0] m, input string rq);
    clr_we = 1'b1; clr_wdata = m;
    @(negedge clk);
    clr_we = 1'b0;
    exp_st[10:0] = exp_st[10:0] & ~m;
    chk(status === exp_st, rq, status, exp_st);
  endtask

  // sends one command and checks every bit of the frame, cycle by cycle
  task automatic send(input logic [5:0] idx, input logic [31:0] arg, input logic rexp,
                      input logic lng, input logic [1:0] extra,
                      input int stall_at, input int poke_at, input int abort_at);
    logic [47:0] fr;
    fr = {2'b01, idx, arg, ref_crc({2'b01, idx, arg}), 1'b1};
    arg_we = 1'b1; arg_wdata = arg;
    @(negedge clk);
    arg_we = 1'b0;
    cmdw_we = 1'b1; cmdw_wdata = {1'b1, extra, lng, rexp, idx};
    @(negedge clk);
    for (int i = 0; i < 48; i++) begin
      arg_we = 1'b0; cmdw_we = 1'b0;
      // R2 R1 per-bit frame and busy
      chk(cmd_oe && status[11] && (cmd_out === fr[47-i]), "R2", {cmd_oe, status[11], cmd_out},
          {2'b11, fr[47-i]});
      if (i == abort_at) begin
        cmdw_we = 1'b1; cmdw_wdata = 11'h000;
        @(negedge clk);
        cmdw_we = 1'b0;
        chk(!status[11] && !cmd_oe && cmd_out, "R10", {status[11], cmd_oe, cmd_out}, 3'b001);
        return;
      end
      if (i == stall_at) begin
        card_tick = 1'b0;
        repeat (5) begin
          @(negedge clk);
          chk(cmd_oe && status[11] && (cmd_out === fr[47-i]), "R11", cmd_out, fr[47-i]);
        end
        card_tick = 1'b1;
      end
      if (i == poke_at) begin
        arg_we = 1'b1; arg_wdata = ~arg;
        cmdw_we = 1'b1; cmdw_wdata = {1'b1, 4'b0000, ~idx};
      end
      @(negedge clk);
    end
    arg_we = 1'b0; cmdw_we = 1'b0;
    if (!rexp) begin
      exp_st[7] = 1'b1;
      chk(status === exp_st && !cmd_oe && cmd_out, "R3", status, exp_st);
    end else begin
      chk(!cmd_oe && status[11], "R4", {cmd_oe, status[11]}, 2'b01);
    end
  endtask

  task automatic respond(input int delay, input logic [135:0] v, input int n, input int flag,
                         input string rq);
    for (int k = 0; k < delay; k++) begin
      cmd_in = 1'b1;
      @(negedge clk);
    end
    chk(status[11] && !status[2], "R4", {status[11], status[2]}, 2'b10);
    for (int j = n - 1; j >= 0; j--) begin
      cmd_in = v[j];
      @(negedge clk);
    end
    cmd_in = 1'b1;
    chk(status[11] === 1'b1, "R1", status[11], 1'b1);
    @(negedge clk);
    exp_st[flag] = 1'b1;
    chk(status === exp_st, rq, status, exp_st);
  endtask

  function automatic logic [135:0] short_rsp(input logic [5:0] idx, input logic [31:0] p,
                                             input logic bad);
    logic [6:0] c;
    c = ref_crc({2'b00, idx, p});
    if (bad) c = ~c;
    return 136'({2'b00, idx, p, c, 1'b1});
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [127:0] lbody;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk(status === 12'h000 && !cmd_oe && cmd_out, "R12", {status, cmd_oe, cmd_out}, 14'h0001);
    check_resp("R12");

    // R2 R3 R11: no-response command, stalled mid-frame
    send(6'd0, 32'h0000_0000, 1'b0, 1'b0, 2'b00, 20, -1, -1);
    clear(11'h080, "R8");

    // R6 long response
    lbody = 128'h3F1C_9A02_55AA_0F0F_DEAD_BEEF_0123_4567;
    send(6'd2, 32'h0, 1'b1, 1'b1, 2'b00, -1, -1, -1);
    exp_r[0] = lbody[127:96]; exp_r[1] = lbody[95:64];
    exp_r[2] = lbody[63:32];  exp_r[3] = lbody[31:0];
    respond(3, {2'b00, 6'h3F, lbody}, 136, 6, "R6");
    check_resp("R6");
    clear(11'h7FF, "R8");

    // R5 short response, good CRC; upper words keep long values
    send(6'd8, 32'h0000_01AA, 1'b1, 1'b0, 2'b00, -1, -1, -1);
    exp_r[0] = 32'h0000_01AA;
    respond(5, short_rsp(6'd8, 32'h0000_01AA, 1'b0), 48, 6, "R5");
    check_resp("R5");

    // R5 short response, bad CRC, flag 6 still sticky
    send(6'd55, 32'h0, 1'b1, 1'b0, 2'b00, -1, -1, -1);
    exp_r[0] = 32'h0000_0120;
    respond(0, short_rsp(6'd55, 32'h0000_0120, 1'b1), 48, 0, "R5");
    check_resp("R5");
    clear(11'h001, "R8");
    clear(11'h7FF, "R8");

    // R7 index 41 with a corrupted CRC
    send(6'd41, 32'h40FF_8000, 1'b1, 1'b0, 2'b00, -1, -1, -1);
    exp_r[0] = 32'h80FF_8000;
    respond(2, short_rsp(6'h3F, 32'h80FF_8000, 1'b1), 48, 6, "R7");
    check_resp("R7");
    clear(11'h7FF, "R8");

    // R4 timeout after 64 silent ticks
    send(6'd8, 32'h1AA, 1'b1, 1'b0, 2'b00, -1, -1, -1);
    repeat (63) @(negedge clk);
    chk(status[11] && !status[2], "R4", {status[11], status[2]}, 2'b10);
    @(negedge clk);
    exp_st[2] = 1'b1;
    chk(status === exp_st && !cmd_oe, "R4", status, exp_st);
    clear(11'h004, "R8");

    // R4 start bit on the last allowed tick
    send(6'd17, 32'h0000_0200, 1'b1, 1'b0, 2'b00, -1, -1, -1);
    exp_r[0] = 32'h0000_0900;
    respond(63, short_rsp(6'd17, 32'h0000_0900, 1'b0), 48, 6, "R4");
    check_resp("R4");
    clear(11'h7FF, "R8");

    // R9 command word bits 8 and 9 set
    send(6'd17, 32'hCAFE_F00D, 1'b0, 1'b0, 2'b11, -1, -1, -1);
    clear(11'h7FF, "R9");

    // R10 launch and argument write during a frame are ignored
    send(6'd3, 32'h1234_5678, 1'b0, 1'b0, 2'b00, -1, 10, -1);
    @(negedge clk);
    chk(!status[11] && !cmd_oe, "R10", {status[11], cmd_oe}, 2'b00);
    clear(11'h7FF, "R10");

    // R10 abort a command that expects a response
    send(6'd4, 32'h0, 1'b1, 1'b0, 2'b00, -1, -1, 5);
    repeat (100) @(negedge clk);
    chk(status === 12'h000, "R10", status, 12'h000);
    check_resp("R10");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule